// File: doc/BRIEF.md
# Register-Driven Multiply-Accumulate Peripheral

This block is a multiplier that a processor drives through a small register window. Software writes the first operand to one of four addresses; the address chosen fixes the operation: plain unsigned product, plain signed product, unsigned accumulate or signed accumulate. Writing the second operand launches the operation. The result is committed on that same clock edge, so the very next bus access already reads it, with no wait cycles.

Each operand can be written as a full 16-bit word or as a single byte. A byte operand is widened to 16 bits by zero fill in unsigned modes and by sign fill in signed modes, so every mix of 8 and 16 bits is covered. The 32-bit result sits in a low and a high word. A third word holds either the carry of an unsigned accumulate or the sign fill of a signed result. The two result words can be written, which lets software preload or clear the accumulator.

Top module: `mac_periph`

## Requirements
- R1: After reset every register reads as zero, and the mode is unsigned multiply.
- R2: A write to byte offset 0x0, 0x2, 0x4 or 0x6 loads the first operand and selects, in that order, unsigned multiply, signed multiply, unsigned accumulate or signed accumulate. Reading any of these four offsets returns the held first operand.
- R3: A write to offset 0x8 loads the second operand and starts the operation. The result words at 0xA (bits 15:0), 0xC (bits 31:16) and the extension word at 0xE hold the new values in the cycle right after the write. Offset 0x8 reads back the widened second operand.
- R4: Unsigned multiply gives the 32-bit unsigned product, and the extension word reads zero.
- R5: Signed multiply gives the two's-complement product. The extension word is 0xFFFF when the result is negative and 0x0000 otherwise.
- R6: Unsigned accumulate adds the unsigned product to the held 32-bit result. The extension word is 1 when that addition carries out of bit 31 and 0 otherwise.
- R7: Signed accumulate adds the signed product to the held result, wrapping modulo 2^32. The extension word holds the sign of the new result: 0xFFFF or 0x0000.
- R8: With the byte select high, a write uses only bits 7:0 of the write data. A first-operand byte is zero-filled or sign-filled according to the mode its address selects. A second-operand byte follows the held mode.
- R9: A new write to the second operand, with no new first operand, repeats the operation with the held first operand and mode. In accumulate modes it adds again.
- R10: Writes to 0xA and 0xC replace the matching result word, with a byte write zero-filled. A write to 0xE has no effect.
- R11: While the write strobe is low, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the accessed register (bits 3:1 decode it) |
| bus_wdata | input | DATA_W | Write data |
| bus_byte | input | 1 | High for an 8-bit write using bits 7:0 |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W | Read data for the addressed register, combinational |

## Verification
The assertions assume a single-port bus: at most one register write per cycle. They also assume that the mode can change only through a first-operand write, so the mode seen with a second-operand write is still in force on the next edge. The stimulus keeps to this by issuing every access through one driver task. That task asserts the strobe for exactly one cycle and follows each launch with reads at separate later cycles. Random operand values and modes are mixed with preloads of the accumulator, so that carries and sign changes occur inside those limits.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    MODE_UMUL  = 2'd0,
    MODE_SMUL  = 2'd1,
    MODE_UACC  = 2'd2,
    MODE_SACC  = 2'd3
  } mac_mode_e;

  typedef enum logic [2:0] {
    SEL_OPA0   = 3'd0,
    SEL_OPA1   = 3'd1,
    SEL_OPA2   = 3'd2,
    SEL_OPA3   = 3'd3,
    SEL_OPB    = 3'd4,
    SEL_RLO    = 3'd5,
    SEL_RHI    = 3'd6,
    SEL_XTD    = 3'd7
  } reg_sel_e;

  function automatic logic mode_is_signed(input mac_mode_e m);
    return m[0];
  endfunction

  function automatic logic mode_is_accum(input mac_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output reg_sel_e          sel,
  output logic              opa_wr,
  output logic              opb_wr,
  output logic              rlo_wr,
  output logic              rhi_wr,
  output mac_mode_e         wr_mode
);
  always_comb begin
    sel     = reg_sel_e'(addr[3:1]);
    wr_mode = mac_mode_e'(addr[2:1]);
    opa_wr  = we && (addr[3] == 1'b0);
    opb_wr  = we && (sel == SEL_OPB);
    rlo_wr  = we && (sel == SEL_RLO);
    rhi_wr  = we && (sel == SEL_RHI);
  end
endmodule

// File: rtl/mac_operands.sv
module mac_operands
  import mac_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opa_wr,
  input  logic              opb_wr,
  input  mac_mode_e         wr_mode,
  input  logic              byte_sel,
  input  logic [DATA_W-1:0] wdata,
  output mac_mode_e         mode_q,
  output logic [DATA_W-1:0] opa_q,
  output logic [DATA_W-1:0] opb_q,
  output logic [DATA_W-1:0] opb_new
);
  localparam int BYTE_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] v,
                                              input logic is_byte,
                                              input logic sgn);
    logic fill;
    fill = sgn & v[BYTE_W-1];
    if (is_byte) return {{(DATA_W-BYTE_W){fill}}, v[BYTE_W-1:0]};
    return v;
  endfunction

  logic [DATA_W-1:0] opa_new;

  always_comb begin
    opa_new = widen(wdata, byte_sel, mode_is_signed(wr_mode));
    opb_new = widen(wdata, byte_sel, mode_is_signed(mode_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_UMUL;
      opa_q  <= '0;
      opb_q  <= '0;
    end else begin
      if (opa_wr) begin
        mode_q <= wr_mode;
        opa_q  <= opa_new;
      end
      if (opb_wr) opb_q <= opb_new;
    end
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  mac_mode_e           mode,
  input  logic [DATA_W-1:0]   opa,
  input  logic [DATA_W-1:0]   opb,
  input  logic [2*DATA_W-1:0] acc,
  output logic [2*DATA_W-1:0] res_next,
  output logic [DATA_W-1:0]   ext_next
);
  localparam int PW = 2 * DATA_W;

  function automatic logic [PW-1:0] stretch(input logic [DATA_W-1:0] v,
                                            input logic sgn);
    return {{DATA_W{sgn & v[DATA_W-1]}}, v};
  endfunction

  function automatic logic [PW-1:0] product(input logic [DATA_W-1:0] a,
                                            input logic [DATA_W-1:0] b,
                                            input logic sgn);
    return stretch(a, sgn) * stretch(b, sgn);
  endfunction

  logic [PW-1:0] prod;
  logic [PW:0]   sum;

  always_comb begin
    prod = product(opa, opb, mode_is_signed(mode));
    sum  = {1'b0, acc} + {1'b0, prod};
    res_next = mode_is_accum(mode) ? sum[PW-1:0] : prod;
    if (mode_is_signed(mode))
      ext_next = {DATA_W{res_next[PW-1]}};
    else if (mode_is_accum(mode))
      ext_next = {{(DATA_W-1){1'b0}}, sum[PW]};
    else
      ext_next = '0;
  end
endmodule

// File: rtl/mac_periph.sv
module mac_periph
  import mac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_byte,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int PW     = 2 * DATA_W;
  localparam int BYTE_W = DATA_W / 2;

  reg_sel_e          sel;
  mac_mode_e         wr_mode, mode_q;
  logic              opa_wr_evt, opb_wr_evt, rlo_wr, rhi_wr, res_wr_evt;
  logic [DATA_W-1:0] opa_q, opb_q, opb_new;
  logic [PW-1:0]     res_q, res_next;
  logic [DATA_W-1:0] ext_q, ext_next, wr_word;

  mac_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .we(bus_we), .sel(sel),
    .opa_wr(opa_wr_evt), .opb_wr(opb_wr_evt),
    .rlo_wr(rlo_wr), .rhi_wr(rhi_wr), .wr_mode(wr_mode)
  );

  mac_operands #(.DATA_W(DATA_W)) u_ops (
    .clk(clk), .rst_n(rst_n), .opa_wr(opa_wr_evt), .opb_wr(opb_wr_evt),
    .wr_mode(wr_mode), .byte_sel(bus_byte), .wdata(bus_wdata),
    .mode_q(mode_q), .opa_q(opa_q), .opb_q(opb_q), .opb_new(opb_new)
  );

  mac_datapath #(.DATA_W(DATA_W)) u_dp (
    .mode(mode_q), .opa(opa_q), .opb(opb_new), .acc(res_q),
    .res_next(res_next), .ext_next(ext_next)
  );

  assign res_wr_evt = rlo_wr | rhi_wr;
  assign wr_word    = bus_byte ? {{(DATA_W-BYTE_W){1'b0}}, bus_wdata[BYTE_W-1:0]}
                               : bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ext_q <= '0;
    end else if (opb_wr_evt) begin
      res_q <= res_next;
      ext_q <= ext_next;
    end else if (rlo_wr) begin
      res_q[DATA_W-1:0] <= wr_word;
    end else if (rhi_wr) begin
      res_q[PW-1:DATA_W] <= wr_word;
    end
  end

  always_comb begin
    case (sel)
      SEL_OPB: bus_rdata = opb_q;
      SEL_RLO: bus_rdata = res_q[DATA_W-1:0];
      SEL_RHI: bus_rdata = res_q[PW-1:DATA_W];
      SEL_XTD: bus_rdata = ext_q;
      default: bus_rdata = opa_q;
    endcase
  end
endmodule

// File: rtl/mac_periph_chk.sv
module mac_periph_chk
  import mac_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                opa_wr_evt,
  input logic                opb_wr_evt,
  input logic                res_wr_evt,
  input mac_mode_e           mode_q,
  input logic [DATA_W-1:0]   opa_q,
  input logic [2*DATA_W-1:0] res_q,
  input logic [DATA_W-1:0]   ext_q
);
  localparam int PW = 2 * DATA_W;

  p_one_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({opa_wr_evt, opb_wr_evt, res_wr_evt}));

  p_opa_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !opa_wr_evt |=> $stable(opa_q) && $stable(mode_q));

  p_result_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !opb_wr_evt && !res_wr_evt |=> $stable(res_q) && $stable(ext_q));

  p_umul_ext_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    opb_wr_evt && mode_q == MODE_UMUL |=> ext_q == '0);

  p_sign_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    opb_wr_evt && mode_q[0] |=> (ext_q == '0 || ext_q == '1) && ext_q[0] == res_q[PW-1]);

  p_carry_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    opb_wr_evt && mode_q == MODE_UACC |=> ext_q[DATA_W-1:1] == '0);

  p_ext_untouched_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr_evt |=> $stable(ext_q));
endmodule

bind mac_periph mac_periph_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .opa_wr_evt(opa_wr_evt), .opb_wr_evt(opb_wr_evt),
  .res_wr_evt(res_wr_evt), .mode_q(mode_q), .opa_q(opa_q),
  .res_q(res_q), .ext_q(ext_q)
);

// File: tb/mac_periph_test.sv
module mac_periph_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_byte = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_rdata;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mac_periph uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_byte(bus_byte), .bus_we(bus_we), .bus_rdata(bus_rdata)
  );

  // independent reference state
  logic [1:0]  m_mode = 0;
  logic [15:0] m_a = 0, m_b = 0, m_ext = 0;
  logic [31:0] m_res = 0;

  typedef struct { logic [15:0] exp; logic [3:0] addr; string tag; } item_t;
  item_t exp_q[$];
  bit rd_flag = 0;

  function automatic logic [15:0] grow(logic [15:0] v, bit is_byte, bit sgn);
    if (!is_byte) return v;
    return (sgn && v[7]) ? {8'hFF, v[7:0]} : {8'h00, v[7:0]};
  endfunction

  function automatic longint as_num(logic [15:0] v, bit sgn);
    if (sgn) return longint'($signed(v));
    return longint'(v);
  endfunction

  task automatic model_launch();
    longint p, s;
    bit sg;
    sg = m_mode[0];
    p = as_num(m_a, sg) * as_num(m_b, sg);
    case (m_mode)
      2'd0: begin m_res = p[31:0]; m_ext = 16'h0; end
      2'd1: begin m_res = p[31:0]; m_ext = m_res[31] ? 16'hFFFF : 16'h0; end
      2'd2: begin s = longint'(m_res) + p; m_res = s[31:0]; m_ext = {15'h0, s[32]}; end
      default: begin
        s = longint'($signed(m_res)) + p; m_res = s[31:0];
        m_ext = m_res[31] ? 16'hFFFF : 16'h0;
      end
    endcase
  endtask

  // entry at posedge+1; leaves at next posedge+1
  task automatic wr(logic [3:0] a, logic [15:0] d, bit by);
    bus_addr = a; bus_wdata = d; bus_byte = by; bus_we = 1'b1;
    case (a[3:1])
      3'd0, 3'd1, 3'd2, 3'd3: begin m_mode = a[2:1]; m_a = grow(d, by, a[1]); end
      3'd4: begin m_b = grow(d, by, m_mode[0]); model_launch(); end
      3'd5: m_res[15:0]  = grow(d, by, 1'b0);
      3'd6: m_res[31:16] = grow(d, by, 1'b0);
      default: ;
    endcase
    @(posedge clk); #1;
    bus_we = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, string tag);
    item_t it;
    case (a[3:1])
      3'd4: it.exp = m_b;
      3'd5: it.exp = m_res[15:0];
      3'd6: it.exp = m_res[31:16];
      3'd7: it.exp = m_ext;
      default: it.exp = m_a;
    endcase
    it.addr = a; it.tag = tag;
    exp_q.push_back(it);
    bus_we = 1'b0; bus_addr = a; rd_flag = 1'b1;
    @(posedge clk); #1;
    rd_flag = 1'b0;
  endtask

  task automatic rd_result(string tag);
    rd(4'hA, tag); rd(4'hC, tag); rd(4'hE, tag);
  endtask

  // monitor: pops expected items mid-cycle
  always @(negedge clk) begin
    if (rd_flag && exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      n_vec++;
      if (bus_rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s addr=0x%0h actual=0x%04h expected=0x%04h",
                 it.tag, it.addr, bus_rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    for (int k = 0; k < 16; k += 2) rd(4'(k), "R1 reset value");

    // R2 R4 unsigned multiply, result on the very next access (R3)
    wr(4'h0, 16'h1234, 0); wr(4'h8, 16'h5678, 0); rd_result("R3 R4 umul");
    rd(4'h0, "R2 opa readback"); rd(4'h6, "R2 opa alias"); rd(4'h8, "R3 opb readback");
    wr(4'h0, 16'hFFFF, 0); wr(4'h8, 16'hFFFF, 0); rd_result("R4 umul max");

    // R5 signed multiply
    wr(4'h2, 16'hFFFF, 0); wr(4'h8, 16'hFFFF, 0); rd_result("R5 smul -1*-1");
    wr(4'h2, 16'h8000, 0); wr(4'h8, 16'h0002, 0); rd_result("R5 smul negative");
    wr(4'h2, 16'h8000, 0); wr(4'h8, 16'h8000, 0); rd_result("R5 smul min*min");

    // R6 unsigned accumulate with carry out
    wr(4'hA, 16'hFFFF, 0); wr(4'hC, 16'hFFFF, 0); rd_result("R10 preload");
    wr(4'h4, 16'h0001, 0); wr(4'h8, 16'h0001, 0); rd_result("R6 uacc carry");
    wr(4'h8, 16'h0003, 0); rd_result("R6 R9 uacc no carry");

    // R7 signed accumulate crossing zero
    wr(4'hA, 16'h0005, 0); wr(4'hC, 16'h0000, 0);
    wr(4'h6, 16'hFFFE, 0); wr(4'h8, 16'h0003, 0); rd_result("R7 sacc to negative");
    wr(4'h8, 16'h0003, 0); rd_result("R7 R9 sacc repeat");
    wr(4'h6, 16'h0004, 0); wr(4'h8, 16'h0002, 0); rd_result("R7 sacc back positive");

    // R8 byte operands
    wr(4'h2, 16'hAB80, 1); rd(4'h2, "R8 opa byte sign fill");
    wr(4'h8, 16'h12FF, 1); rd(4'h8, "R8 opb byte sign fill"); rd_result("R8 smul bytes");
    wr(4'h0, 16'hAB80, 1); rd(4'h0, "R8 opa byte zero fill");
    wr(4'h8, 16'h3412, 0); rd_result("R8 8x16 umul");
    wr(4'h0, 16'h8001, 0); wr(4'h8, 16'h77F0, 1); rd_result("R8 16x8 umul");

    // R9 repeat with held first operand
    wr(4'h8, 16'h0010, 0); rd_result("R9 repeat umul");

    // R10 result words writable, extension word write ignored
    wr(4'hC, 16'hBEEF, 1); rd(4'hC, "R10 rhi byte write");
    wr(4'hE, 16'h1234, 0); rd(4'hE, "R10 ext write ignored");

    // R11 strobe low: nothing changes
    bus_addr = 4'h8; bus_wdata = 16'h4444; bus_we = 1'b0;
    @(posedge clk); #1;
    bus_addr = 4'h2; bus_wdata = 16'h5555;
    @(posedge clk); #1;
    rd_result("R11 no strobe"); rd(4'h2, "R11 opa kept"); rd(4'h8, "R11 opb kept");

    // random mix across modes and widths
    for (int i = 0; i < 200; i++) begin
      logic [1:0] md;
      md = 2'($urandom_range(0, 3));
      if ((i % 17) == 0) begin
        wr(4'hA, 16'($urandom), 0); wr(4'hC, 16'($urandom), 0);
      end
      wr({1'b0, md, 1'b0}, 16'($urandom), bit'($urandom_range(0, 1)));
      wr(4'h8, 16'($urandom), bit'($urandom_range(0, 1)));
      case (md)
        2'd0: rd_result("R4 random");
        2'd1: rd_result("R5 random");
        2'd2: rd_result("R6 random");
        default: rd_result("R7 random");
      endcase
    end

    @(posedge clk); #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule